// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block is an interrupt controller with eight request inputs. Software reaches it through a two-address register port: address 0 takes commands and address 1 takes data. After reset the block does nothing until software runs an initialization sequence. That sequence sets the vector base, says whether a cascade word follows, and says whether end-of-interrupt is automatic or explicit. The block then holds a request register, a mask register and an in-service register, each 8 bits wide. It drives one interrupt line towards the processor.

The processor answers the interrupt line with two acknowledge pulses. The first pulse picks the winning input, moves it from request to in-service, and clears its request bit. During the second pulse the block drives the 8-bit vector. If the request has gone away by the first pulse, the controller answers with the input 7 vector and leaves in-service unchanged. Software ends service either with an end-of-interrupt command or, in automatic mode, by letting the block clear the bit itself.

Top module: `vic8`

## Requirements
- R1: After reset, `int_out` is 0, the mask register reads 0xFF, and the request and in-service registers are 0.
- R2: A command write with bit 4 set starts initialization. It clears the mask and in-service registers and selects request readback. In that first word, bit 0 set means a fourth word follows, and bit 1 set means the third word is skipped. The data writes that follow are taken in order as the second, third and fourth words. The third word (the cascade description) is accepted and discarded. `int_out` stays 0 until the last word has been written.
- R3: The vector for input n is the second initialization word's bits 7:3 followed by n in bits 2:0. A base of 0x20 gives 0x20–0x27, and a base of 0x48 gives 0x48–0x4F.
- R4: Once initialization is complete, a data write loads the mask, where a 1 blocks that input, and a data read returns the mask.
- R5: Command writes of 0x0A and 0x0B make later command-address reads return the request register or the in-service register. The choice holds until another such command or a new initialization.
- R6: Priority is fixed, with input 0 highest. `int_out` is 1 only when there is a pending unmasked request and no in-service bit of equal or higher priority is set.
- R7: A request bit is set by a rising edge on its input. It is cleared when that input is low, and also when the request is acknowledged, even if the input stays high.
- R8: The first acknowledge pulse sets the winner's in-service bit and clears its request bit. During the second pulse `vec_valid` is 1 and `vec_out` carries the vector. At all other times `vec_valid` is 0.
- R9: A command write of 0x60+n clears in-service bit n and no other bit.
- R10: A command write of 0x20 clears the highest-priority in-service bit that is set.
- R11: When the fourth word has bit 1 set, the in-service bit is cleared at the end of the second acknowledge pulse.
- R12: If no unmasked request qualifies at the first pulse, the vector is base+7 and in-service is left unchanged. This also holds when input 7 is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current `addr` |
| irq_in | input | 8 | Interrupt request inputs |
| int_out | output | 1 | Interrupt line to the processor |
| ack | input | 1 | Acknowledge pulse, one cycle per pulse |
| vec_valid | output | 1 | Vector is driven during this second pulse |
| vec_out | output | 8 | Interrupt vector |

## Verification
The bench checks how the cascade-word skip interacts with the fourth word. A design that counted the words wrongly would treat a data write as the mask, or would leave the block stuck in initialization. It checks a request that drops before the acknowledge: a wrong design would set a stale in-service bit or return a vector other than base+7. It checks that a higher-priority request preempts a lower one that is already in service, while a lower one is held off. It also checks that specific and non-specific end-of-interrupt each clear exactly the intended bit, so a design that cleared every bit, or the wrong bit, would release lower-priority requests too early.

// File: rtl/vic8.sv
module vic8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       ack,
  output logic       vec_valid,
  output logic [7:0] vec_out
);
  typedef enum logic [2:0] {S_IDLE, S_W2, S_W3, S_W4, S_RUN} seq_t;

  seq_t       seq;
  logic [7:0] irr, imr, isr, prev, irr_n, isr_n;
  logic [4:0] base;
  logic       need_w4, single, aeoi, sel_isr, phase, spur;
  logic [2:0] idx, win, top_isr;
  logic       found, blocked, cand, run, cmd_wr, dat_wr;

  assign run    = (seq == S_RUN);
  assign cmd_wr = wr_en && !addr;
  assign dat_wr = wr_en && addr;

  always_comb begin
    win = '0;
    found = 1'b0;
    for (int i = 7; i >= 0; i--)
      if (irr[i] && !imr[i]) begin
        win = 3'(i);
        found = 1'b1;
      end
    blocked = 1'b0;
    for (int i = 0; i < 8; i++)
      if (isr[i] && 3'(i) <= win) blocked = 1'b1;
    top_isr = '0;
    for (int i = 7; i >= 0; i--)
      if (isr[i]) top_isr = 3'(i);
  end

  assign cand    = run && found && !blocked;
  assign int_out = cand;

  always_comb begin
    irr_n = (irr | (irq_in & ~prev)) & irq_in;
    isr_n = isr;
    if (ack && !phase && cand) begin
      isr_n[win] = 1'b1;
      irr_n[win] = 1'b0;
    end
    if (ack && phase && aeoi && !spur) isr_n[idx] = 1'b0;
    if (cmd_wr && wdata[4]) isr_n = '0;
    else if (cmd_wr && run && wdata[4:3] == 2'b00) begin
      if (wdata[7:5] == 3'b011) isr_n[wdata[2:0]] = 1'b0;
      else if (wdata[7:5] == 3'b001 && |isr) isr_n[top_isr] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq     <= S_IDLE;
      irr     <= '0;
      imr     <= 8'hFF;
      isr     <= '0;
      prev    <= '0;
      base    <= '0;
      need_w4 <= 1'b0;
      single  <= 1'b0;
      aeoi    <= 1'b0;
      sel_isr <= 1'b0;
      phase   <= 1'b0;
      spur    <= 1'b0;
      idx     <= '0;
    end else begin
      prev <= irq_in;
      irr  <= irr_n;
      isr  <= isr_n;
      if (ack) begin
        if (!phase) begin
          phase <= 1'b1;
          idx   <= cand ? win : 3'd7;
          spur  <= !cand;
        end else begin
          phase <= 1'b0;
        end
      end
      if (cmd_wr && wdata[4]) begin
        seq     <= S_W2;
        need_w4 <= wdata[0];
        single  <= wdata[1];
        imr     <= '0;
        sel_isr <= 1'b0;
        aeoi    <= 1'b0;
      end else if (cmd_wr && run && wdata[4:3] == 2'b01 && wdata[1]) begin
        sel_isr <= wdata[0];
      end
      if (dat_wr) begin
        case (seq)
          S_W2: begin
            base <= wdata[7:3];
            seq  <= single ? (need_w4 ? S_W4 : S_RUN) : S_W3;
          end
          S_W3: seq <= need_w4 ? S_W4 : S_RUN;
          S_W4: begin
            aeoi <= wdata[1];
            seq  <= S_RUN;
          end
          S_RUN: imr <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign rdata     = addr ? imr : (sel_isr ? isr : irr);
  assign vec_valid = ack && phase;
  assign vec_out   = vec_valid ? {base, idx} : 8'h00;
endmodule

// File: rtl/vic8_chk.sv
module vic8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic [7:0] irq_in,
  input logic       ack,
  input logic       int_out,
  input logic       vec_valid,
  input logic [7:0] irr,
  input logic [7:0] imr,
  input logic [7:0] isr,
  input logic       phase
);
  p_vec_in_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ack);

  p_int_needs_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~imr) != 8'h00));

  p_isr_set_by_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr & ~$past(isr)) != 8'h00) |-> $past(ack && !phase));

  p_spur_keeps_isr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !phase && ((irr & ~imr) == 8'h00) && !wr_en) |=> $stable(isr));

  p_spec_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[7:3] == 5'b01100 && !ack) |=> !isr[$past(wdata[2:0])]);

  p_irr_follows_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irr & ~$past(irq_in)) == 8'h00);
endmodule

bind vic8 vic8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq_in(irq_in), .ack(ack), .int_out(int_out), .vec_valid(vec_valid),
  .irr(irr), .imr(imr), .isr(isr), .phase(phase)
);

// File: tb/vic8_test.sv
module vic8_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, addr = 0, ack = 0;
  logic [7:0] wdata = 0, irq_in = 0;
  logic [7:0] rdata, vec_out;
  logic int_out, vec_valid;
  int checks = 0, failures = 0;
  bit done = 0;

  vic8 uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
            .rdata(rdata), .irq_in(irq_in), .int_out(int_out), .ack(ack),
            .vec_valid(vec_valid), .vec_out(vec_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  int ms, midx;
  bit m4, msg, maeoi, msel, mph, msp;
  logic [7:0] mirr, mimr, misr, mprev;
  logic [4:0] mbase;

  function automatic int mcand();
    if (ms != 4) return -1;
    for (int i = 0; i < 8; i++)
      if (mirr[i] && !mimr[i]) begin
        for (int j = 0; j <= i; j++) if (misr[j]) return -1;
        return i;
      end
    return -1;
  endfunction

  always @(posedge clk) begin : model
    int w;
    logic [7:0] ni;
    if (!rst_n) begin
      ms = 0; midx = 0; m4 = 0; msg = 0; maeoi = 0; msel = 0; mph = 0; msp = 0;
      mirr = 0; mimr = 8'hFF; misr = 0; mprev = 0; mbase = 0;
    end else begin
      w = mcand();
      ni = mirr;
      for (int i = 0; i < 8; i++) begin
        if (irq_in[i] && !mprev[i]) ni[i] = 1;
        if (!irq_in[i]) ni[i] = 0;
      end
      if (ack) begin
        if (!mph) begin
          if (w >= 0) begin misr[w] = 1; ni[w] = 0; midx = w; msp = 0; end
          else begin midx = 7; msp = 1; end
          mph = 1;
        end else begin
          if (maeoi && !msp) misr[midx] = 0;
          mph = 0;
        end
      end
      mirr = ni;
      mprev = irq_in;
      if (wr_en && !addr) begin
        if (wdata[4]) begin
          ms = 1; m4 = wdata[0]; msg = wdata[1]; mimr = 0; misr = 0; msel = 0; maeoi = 0;
        end else if (ms == 4) begin
          if (wdata[4:3] == 2'b01 && wdata[1]) msel = wdata[0];
          if (wdata[4:3] == 2'b00 && wdata[7:5] == 3'b011) misr[wdata[2:0]] = 0;
          if (wdata[4:3] == 2'b00 && wdata[7:5] == 3'b001)
            for (int k = 0; k < 8; k++) if (misr[k]) begin misr[k] = 0; break; end
        end
      end
      if (wr_en && addr) begin
        case (ms)
          1: begin mbase = wdata[7:3]; ms = msg ? (m4 ? 3 : 4) : 2; end
          2: ms = m4 ? 3 : 4;
          3: begin maeoi = wdata[1]; ms = 4; end
          4: mimr = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic [7:0] er;
    er = addr ? mimr : (msel ? misr : mirr);
    chk("R6 int_out model", {7'd0, int_out}, {7'd0, mcand() >= 0});
    chk("R5 rdata model", rdata, er);
    chk("R8 vec_valid model", {7'd0, vec_valid}, {7'd0, ack && mph});
    chk("R3 vec_out model", vec_out, (ack && mph) ? {mbase, 3'(midx)} : 8'h00);
  end

  task automatic wr(logic a, logic [7:0] d);
    @(posedge clk); #1; wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(posedge clk); #1; addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(posedge clk); #1; ack = 1;
    @(posedge clk); #1; ack = 0;
    @(posedge clk); #1; ack = 1;
    @(negedge clk); v = vec_out;
    @(posedge clk); #1; ack = 0;
  endtask

  task automatic set_irq(int n, logic v);
    @(posedge clk); #1; irq_in[n] = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, v;
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    chk("R1 int_out after reset", {7'd0, int_out}, 8'h00);
    rd(1, d); chk("R1 mask after reset", d, 8'hFF);
    rd(0, d); chk("R1 request after reset", d, 8'h00);

    wr(0, 8'h11);
    wr(1, 8'h20);
    set_irq(3, 1);
    settle(); chk("R2 int held low during init", {7'd0, int_out}, 8'h00);
    wr(1, 8'h04);
    wr(1, 8'h01);
    @(negedge clk); chk("R6 int after init", {7'd0, int_out}, 8'h01);
    rd(1, d); chk("R2 mask cleared by init", d, 8'h00);

    do_ack(v); chk("R3 vector input3", v, 8'h23);
    rd(0, d); chk("R7 request cleared by ack", d, 8'h00);
    wr(0, 8'h0B);
    rd(0, d); chk("R5 in-service readback", d, 8'h08);
    rd(1, d);
    rd(0, d); chk("R5 selection persists", d, 8'h08);

    @(posedge clk); #1; irq_in[1] = 1; irq_in[5] = 1;
    settle(); chk("R6 higher priority preempts", {7'd0, int_out}, 8'h01);
    do_ack(v); chk("R8 vector input1", v, 8'h21);
    rd(0, d); chk("R8 in-service after ack", d, 8'h0A);
    wr(0, 8'h61);
    rd(0, d); chk("R9 specific eoi", d, 8'h08);
    settle(); chk("R6 lower request held off", {7'd0, int_out}, 8'h00);
    wr(0, 8'h20);
    rd(0, d); chk("R10 nonspecific eoi", d, 8'h00);
    settle(); chk("R6 released after eoi", {7'd0, int_out}, 8'h01);
    wr(1, 8'h20);
    settle(); chk("R4 masked input blocked", {7'd0, int_out}, 8'h00);
    rd(1, d); chk("R4 mask readback", d, 8'h20);
    wr(1, 8'h00);
    set_irq(5, 0);
    settle(); chk("R7 request dropped with input", {7'd0, int_out}, 8'h00);
    wr(0, 8'h0A);
    rd(0, d); chk("R7 request register after drop", d, 8'h00);

    @(posedge clk); #1; irq_in = 0;
    set_irq(6, 1);
    settle(); chk("R6 input6 pending", {7'd0, int_out}, 8'h01);
    set_irq(6, 0);
    settle();
    do_ack(v); chk("R12 spurious vector", v, 8'h27);
    wr(0, 8'h0B);
    rd(0, d); chk("R12 in-service untouched", d, 8'h00);
    wr(1, 8'h80);
    do_ack(v); chk("R12 spurious with input7 masked", v, 8'h27);
    rd(0, d); chk("R12 in-service still clear", d, 8'h00);

    wr(0, 8'h13);
    rd(1, d); chk("R2 reinit clears mask", d, 8'h00);
    wr(1, 8'h48);
    wr(1, 8'h03);
    set_irq(2, 1);
    settle();
    rd(0, d); chk("R2 request readback selected", d, 8'h04);
    chk("R2 running after skipped word", {7'd0, int_out}, 8'h01);
    do_ack(v); chk("R3 vector with new base", v, 8'h4A);
    wr(0, 8'h0B);
    rd(0, d); chk("R11 automatic eoi", d, 8'h00);
    set_irq(2, 0);
    settle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule